// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider Controller

This block sits in the feedback path of a frequency synthesizer. It sits after an external two-ratio prescaler that divides the oscillator by P+1 or by P. The block counts the prescaler's output events with two down-counters: a main count of width NW and a swallow count of width AW. From these counts it produces the prescaler's ratio-select line. While swallow periods remain, the select line is low and the prescaler divides by P+1. After that it is high and the prescaler divides by P. When the main count completes, the block emits one feedback strobe to the phase comparator and reloads both counts. One full cycle therefore spans N·P + A oscillator periods.

`fin_pulse` is a single-clock strobe in the `clk` domain, one per rising edge of the prescaler output. It is synchronized upstream. The prescaler cannot be stalled, so the event input has no back-pressure and no handshake. `n_prog` and `a_prog` are plain configuration levels held by a register elsewhere. The block copies them only when it reloads. `mod_ctl` and `fv_pulse` change on the clock edge that samples a strobe, and are visible in the following cycle. The values must satisfy 3 ≤ N ≤ 2^NW−1 and 0 ≤ A ≤ min(N, 2^AW−1).

Top module: `dmod_divider_ctrl`

## Requirements
- R1: While `rst_n` is low, `mod_ctl` and `fv_pulse` are 0. On the first clock edge after release, both counts load `n_prog`/`a_prog` and `fin_pulse` is ignored. From the next cycle on, `mod_ctl` is 1 exactly when the loaded A is 0.
- R2: Each strobe steps the main count down by one. Each strobe also steps the swallow count down while it is nonzero; once at zero, it holds. A cycle consists of exactly N strobes.
- R3: Within a cycle, `mod_ctl` is 0 during the first A prescaler periods and 1 during the remaining N−A periods.
- R4: The N-th strobe of a cycle reloads both counts. In the next clock cycle, `mod_ctl` is 0 whenever the reloaded A is nonzero.
- R5: `fv_pulse` is high for exactly one clock cycle, in the cycle after the N-th strobe, and is low at all other times.
- R6: With a prescaler that divides by P+1 while `mod_ctl` is 0 and by P while it is 1, one cycle spans N·P + A oscillator periods.
- R7: With A = 0, `mod_ctl` stays 1 for the whole cycle.
- R8: With A = N, `mod_ctl` stays 0 for the whole cycle, so the cycle spans N·(P+1) periods.
- R9: A change of `n_prog`/`a_prog` during a cycle does not alter that cycle. The new values take effect only from the next reload.
- R10: The extremes N = 2^NW−1 with A = 2^AW−1 divide correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fin_pulse | input | 1 | One-clock strobe per prescaler output rising edge |
| n_prog | input | NW | Programmed main count N |
| a_prog | input | AW | Programmed swallow count A |
| mod_ctl | output | 1 | Prescaler ratio select: 0 selects P+1, 1 selects P |
| fv_pulse | output | 1 | One-clock feedback strobe per completed cycle |

## Verification
The bench models the prescaler and sweeps every legal pair (N, A) of a small range against three values of P. In each cycle it counts oscillator periods, strobes and P+1 periods against N·P+A, N and A. The sweep includes A = 0 and A = N. A design that updates the ratio select one strobe late would show a count off by one period. A design that let the swallow count wrap past zero would leave `mod_ctl` low too long when A = 0. Every reprogramming happens in the middle of a cycle, so a design that reloaded early would show the new ratio one cycle too soon. A final run at the largest N and A exposes any truncation of the count widths.

// File: rtl/dmod_pkg.sv
package dmod_pkg;
  // Controller phase: waiting for first load after reset, or counting.
  typedef enum logic {
    PH_LOAD = 1'b0,
    PH_RUN  = 1'b1
  } dmod_phase_e;
endpackage

// File: rtl/dmod_ncount.sv
module dmod_ncount #(
  parameter int unsigned NW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [NW-1:0] load_val,
  output logic [NW-1:0] cnt,
  output logic          last
);
  localparam logic [NW-1:0] ONE = NW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (step) cnt <= cnt - ONE;
  end

  // terminal state is 1, so the N-th event reloads instead of reaching 0
  assign last = (cnt == ONE);

  // R2: a step without reload never lands on zero from a live count
  p_step_keeps_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt > ONE) |=> (cnt != '0));
endmodule

// File: rtl/dmod_acount.sv
module dmod_acount #(
  parameter int unsigned AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] cnt,
  output logic          mod_hi
);
  logic [AW-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (load)                   cnt_nxt = load_val;
    else if (step && cnt != '0) cnt_nxt = cnt - AW'(1);
  end

  // select line registered from next state: glitch-free and aligned with cnt
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      mod_hi <= 1'b0;
    end else begin
      cnt    <= cnt_nxt;
      mod_hi <= (cnt_nxt == '0);
    end
  end

  // R2: once exhausted, the swallow count holds at zero until reload
  p_zero_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load) |=> (cnt == '0));
endmodule

// File: rtl/dmod_divider_ctrl.sv
module dmod_divider_ctrl #(
  parameter int unsigned NW = 10,
  parameter int unsigned AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fin_pulse,
  input  logic [NW-1:0] n_prog,
  input  logic [AW-1:0] a_prog,
  output logic          mod_ctl,
  output logic          fv_pulse
);
  import dmod_pkg::*;

  dmod_phase_e   phase;
  logic [NW-1:0] n_cnt;
  logic [AW-1:0] a_cnt;
  logic          n_last, running, reload, advance, fv_q;

  assign running = (phase == PH_RUN);
  assign reload  = !running || (fin_pulse && n_last);
  assign advance = running && fin_pulse && !n_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_LOAD;
      fv_q  <= 1'b0;
    end else begin
      phase <= PH_RUN;
      fv_q  <= running && fin_pulse && n_last;
    end
  end

  dmod_ncount #(.NW(NW)) u_ncnt (
    .clk(clk), .rst_n(rst_n), .load(reload), .step(advance),
    .load_val(n_prog), .cnt(n_cnt), .last(n_last)
  );

  dmod_acount #(.AW(AW)) u_acnt (
    .clk(clk), .rst_n(rst_n), .load(reload), .step(advance),
    .load_val(a_prog), .cnt(a_cnt), .mod_hi(mod_ctl)
  );

  assign fv_pulse = fv_q;

  // R2: while counting, the main count stays within 1..N
  p_ncnt_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (n_cnt != '0));
  // R3: swallow count never exceeds the remaining main count
  p_a_within_n_r3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (NW'(a_cnt) <= n_cnt));
  // R3: select line only rises after a strobe or the initial load
  p_mod_rise_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_ctl) |-> ($past(fin_pulse) || $past(phase == PH_LOAD)));
  // R4: select line only falls together with the feedback strobe (reload)
  p_mod_fall_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_ctl) |-> fv_pulse);
  // R5: feedback strobe follows a sampled input strobe
  p_fv_after_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fv_pulse |-> $past(fin_pulse));
  // R9: the reload copies the programmed value seen on that edge
  p_reload_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fv_pulse |-> (n_cnt == $past(n_prog)));
endmodule

// File: tb/sim_dmod_divider_ctrl.sv
`timescale 1ns/1ps
module sim_dmod_divider_ctrl;
  localparam int NW = 10;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fin = 1'b0;
  logic [NW-1:0] n_prog = '0;
  logic [AW-1:0] a_prog = '0;
  logic          mod_ctl, fv_pulse;

  int errors = 0;
  int checks = 0;
  int pval   = 4;
  bit ended  = 1'b0;

  always #2 clk = ~clk;

  dmod_divider_ctrl #(.NW(NW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .fin_pulse(fin), .n_prog(n_prog),
    .a_prog(a_prog), .mod_ctl(mod_ctl), .fv_pulse(fv_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Prescaler model: one feedback cycle, ratio chosen at each period start.
  task automatic run_cycle(output int vco, output int periods, output int lows,
                           output int first_low, output int fv_extra);
    bit done = 1'b0;
    vco = 0; periods = 0; lows = 0; first_low = 0; fv_extra = 0;
    while (!done) begin
      bit low = !mod_ctl;
      int len = low ? pval + 1 : pval;
      if (periods == 0) first_low = int'(low);
      if (low) lows++;
      for (int i = 1; i < len; i++) begin
        @(negedge clk);
        if (fv_pulse) fv_extra++;
      end
      fin = 1'b1;
      @(negedge clk);
      fin = 1'b0;
      vco += len;
      periods++;
      if (fv_pulse || periods > 3000) done = 1'b1;
    end
  endtask

  task automatic measure(input int n, input int a, input string tag);
    int vco, periods, lows, first_low, fv_extra;
    string lt;
    run_cycle(vco, periods, lows, first_low, fv_extra);
    lt = (a == 0) ? "R7" : ((a == n) ? "R8" : "R3");
    chk(vco == n * pval + a, tag, vco, n * pval + a);
    chk(periods == n, "R2", periods, n);
    chk(lows == a, lt, lows, a);
    chk(first_low == int'(a > 0), "R4", first_low, int'(a > 0));
    chk(fv_extra == 0, "R5", fv_extra, 0);
  endtask

  initial begin
    int pn, pa;
    int plist[3] = '{3, 4, 8};
    n_prog = NW'(5);
    a_prog = AW'(0);
    repeat (3) @(negedge clk);
    chk(mod_ctl == 1'b0, "R1", int'(mod_ctl), 0);
    chk(fv_pulse == 1'b0, "R1", int'(fv_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mod_ctl == 1'b1, "R1", int'(mod_ctl), 1);
    chk(fv_pulse == 1'b0, "R1", int'(fv_pulse), 0);
    measure(5, 0, "R6");
    pn = 5; pa = 0;
    foreach (plist[k]) begin
      pval = plist[k];
      for (int n = 3; n <= 10; n++) begin
        for (int a = 0; a <= n; a++) begin
          n_prog = NW'(n);
          a_prog = AW'(a);
          measure(pn, pa, "R9");  // cycle in flight keeps the old values
          measure(n, a, "R6");
          pn = n; pa = a;
        end
      end
    end
    // R10: widest legal values
    pval = 8;
    n_prog = NW'((1 << NW) - 1);
    a_prog = AW'((1 << AW) - 1);
    measure(pn, pa, "R9");
    measure((1 << NW) - 1, (1 << AW) - 1, "R10");
    ended = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!ended) begin
      checks++;
      errors++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule